// File: doc/BRIEF.md
# Four-Function ALU with Carry and Borrow Chaining

This block is a purely combinational arithmetic and logic unit. It takes two operands, a two-bit function code, an incoming flag word and a chain-enable bit. It returns a result of the operand width and an outgoing flag word. The four functions are addition, subtraction (P minus Q), bitwise AND and bitwise OR.

Carry and borrow live in two separate bits of the flag word, each at a fixed position. The carry sits at bit 0 and the borrow at bit 1, on the way in and on the way out. When chain-enable is high, the adder adds the incoming carry and the subtractor takes away the incoming borrow. A sequencer can then feed the outgoing flag word of one operation back in as the incoming flag word of the next, and so build add-with-carry and subtract-with-borrow over words wider than one operand. The flag register and the multi-word sequencing belong to the surrounding datapath.

Top module: `alu_chain`

## Requirements
- R1: The function code selects the result: 2'b00 addition, 2'b01 subtraction P minus Q, 2'b10 bitwise AND, 2'b11 bitwise OR.
- R2: For addition, {flag_out[0], result} equals P + Q + cin as a five-bit sum, where cin = chain_en AND flag_in[0].
- R3: For subtraction, result equals (P - Q - bin) modulo 16, where bin = chain_en AND flag_in[1]. flag_out[1] is 1 exactly when P < Q + bin.
- R4: With chain_en low, flag_in has no effect on either output. Addition gives P + Q and subtraction gives P - Q, with no carry-in or borrow-in.
- R5: flag_out[0] (the adder carry) and flag_out[1] (the subtractor borrow) are computed and driven for every function code, not only for the one that is selected.
- R6: flag_out[3:2] is always 2'b00, whatever the inputs.
- R7: For the AND code, every result bit is the AND of the matching bits of P and Q.
- R8: For the OR code, every result bit is the OR of the matching bits of P and Q.
- R9: The block has no clock and no state. The outputs depend only on the present inputs and follow an input change with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Function code: add, subtract, AND, OR |
| opnd_p | input | 4 | First operand P |
| opnd_q | input | 4 | Second operand Q |
| flag_in | input | 4 | Incoming flags: bit 0 carry, bit 1 borrow |
| chain_en | input | 1 | Lets the incoming carry and borrow take part |
| result | output | 4 | Result of the selected function |
| flag_out | output | 4 | Outgoing flags: bit 0 carry-out, bit 1 borrow-out, upper bits zero |

## Verification
Addition and subtraction are swept over every P, Q and carry-in or borrow-in value with chaining on. This separates a correct carry or borrow chain from one that drops the chained bit, misroutes a carry or inverts the borrow sense. A second sweep sets every flag_in bit high and turns chaining off, to show that the enable really gates the flags. Every flag_out bit is compared on all four function codes, so a flag that is only produced under its own code, or a swapped bit position, shows up. AND and OR are swept over all operand pairs, which separates the two logic functions from each other and from the arithmetic paths.

// File: rtl/alu_chain_pkg.sv
package alu_chain_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu_fn_e;

  localparam int unsigned CARRY_BIT  = 0;
  localparam int unsigned BORROW_BIT = 1;
endpackage

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         c_in,
  output logic [W-1:0] sum_out,
  output logic         c_out
);
  logic [W:0] chain;

  assign chain[0] = c_in;

  for (genvar k = 0; k < W; k++) begin : g_cell
    assign sum_out[k]  = a_in[k] ^ b_in[k] ^ chain[k];
    assign chain[k+1]  = (a_in[k] & b_in[k]) | (a_in[k] & chain[k]) | (b_in[k] & chain[k]);
  end

  assign c_out = chain[W];

  // R2: the ripple chain matches arithmetic addition
  always_comb begin
    if (!$isunknown({a_in, b_in, c_in})) begin
      a_r2_add_sum: assert ({c_out, sum_out} == ({1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in}))
        else $error("adder chain mismatch");
    end
  end
endmodule

// File: rtl/alu_ripple_sub.sv
module alu_ripple_sub #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         bw_in,
  output logic [W-1:0] diff_out,
  output logic         bw_out
);
  logic [W:0] chain;

  assign chain[0] = bw_in;

  for (genvar k = 0; k < W; k++) begin : g_cell
    assign diff_out[k] = a_in[k] ^ b_in[k] ^ chain[k];
    assign chain[k+1]  = (~a_in[k] & b_in[k]) | (~a_in[k] & chain[k]) | (b_in[k] & chain[k]);
  end

  assign bw_out = chain[W];

  // R3: borrow out is set exactly when the true difference is negative
  always_comb begin
    if (!$isunknown({a_in, b_in, bw_in})) begin
      a_r3_sub_borrow: assert (bw_out == ({1'b0, a_in} < ({1'b0, b_in} + {{W{1'b0}}, bw_in})))
        else $error("subtractor borrow mismatch");
      a_r3_sub_diff: assert (diff_out == W'(a_in - b_in - {{(W-1){1'b0}}, bw_in}))
        else $error("subtractor difference mismatch");
    end
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] and_out,
  output logic [W-1:0] or_out
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign and_out[k] = a_in[k] & b_in[k];
    assign or_out[k]  = a_in[k] | b_in[k];
  end

  // R7, R8: the AND result lies inside both operands, the OR result covers both
  always_comb begin
    if (!$isunknown({a_in, b_in})) begin
      a_r7_and_subset: assert (((and_out & ~a_in) == '0) && ((and_out & ~b_in) == '0))
        else $error("AND result outside operands");
      a_r8_or_cover: assert (((a_in | b_in) & ~or_out) == '0)
        else $error("OR result misses operand bits");
    end
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain #(
  parameter int unsigned W      = 4,
  parameter int unsigned FLAG_W = 4
) (
  input  logic [1:0]        op_sel,
  input  logic [W-1:0]      opnd_p,
  input  logic [W-1:0]      opnd_q,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic              chain_en,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flag_out
);
  import alu_chain_pkg::*;

  localparam int unsigned SPARE_W = FLAG_W - 2;

  alu_fn_e     fn;
  logic        cin_gated;
  logic        bin_gated;
  logic [W-1:0] add_y, sub_y, and_y, or_y;
  logic        add_c, sub_b;
  logic        unused_spare_flags;

  assign fn        = alu_fn_e'(op_sel);
  assign cin_gated = chain_en & flag_in[CARRY_BIT];
  assign bin_gated = chain_en & flag_in[BORROW_BIT];
  assign unused_spare_flags = ^flag_in[FLAG_W-1:2];

  alu_ripple_add #(.W(W)) u_add (
    .a_in    (opnd_p),
    .b_in    (opnd_q),
    .c_in    (cin_gated),
    .sum_out (add_y),
    .c_out   (add_c)
  );

  alu_ripple_sub #(.W(W)) u_sub (
    .a_in     (opnd_p),
    .b_in     (opnd_q),
    .bw_in    (bin_gated),
    .diff_out (sub_y),
    .bw_out   (sub_b)
  );

  alu_bitwise #(.W(W)) u_bit (
    .a_in    (opnd_p),
    .b_in    (opnd_q),
    .and_out (and_y),
    .or_out  (or_y)
  );

  always_comb begin
    unique case (fn)
      FN_ADD:  result = add_y;
      FN_SUB:  result = sub_y;
      FN_AND:  result = and_y;
      default: result = or_y;
    endcase
  end

  always_comb begin
    flag_out             = '0;
    flag_out[CARRY_BIT]  = add_c;
    flag_out[BORROW_BIT] = sub_b;
  end

  // R4: with chaining off, the add and subtract results ignore flag_in
  always_comb begin
    if (!$isunknown({op_sel, opnd_p, opnd_q, chain_en})) begin
      if (!chain_en && fn == FN_ADD) begin
        a_r4_add_unchained: assert ({flag_out[CARRY_BIT], result} == ({1'b0, opnd_p} + {1'b0, opnd_q}))
          else $error("add used carry while chaining was off");
      end
      if (!chain_en && fn == FN_SUB) begin
        a_r4_sub_unchained: assert (result == W'(opnd_p - opnd_q))
          else $error("subtract used borrow while chaining was off");
      end
      // R6: spare flag bits stay clear
      a_r6_spare_zero: assert (flag_out[FLAG_W-1:2] == {SPARE_W{1'b0}})
        else $error("spare flag bits set");
    end
  end
endmodule

// File: tb/test_alu_chain.sv
module test_alu_chain;
  logic [1:0] op_sel;
  logic [3:0] opnd_p, opnd_q, flag_in;
  logic       chain_en;
  logic [3:0] result, flag_out;
  logic       clk;
  logic       done;
  int         checks;
  int         fails;

  alu_chain i_alu_chain (
    .op_sel   (op_sel),
    .opnd_p   (opnd_p),
    .opnd_q   (opnd_q),
    .flag_in  (flag_in),
    .chain_en (chain_en),
    .result   (result),
    .flag_out (flag_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s p=%h q=%h op=%b fin=%h en=%b actual=%h expected=%h",
               req, opnd_p, opnd_q, op_sel, flag_in, chain_en, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [3:0] p, input logic [3:0] q,
                       input logic [3:0] fi, input logic en);
    op_sel = op; opnd_p = p; opnd_q = q; flag_in = fi; chain_en = en;
    #5;
  endtask

  task automatic t_add_chain();
    for (int i = 0; i < 512; i++) begin
      logic [4:0] s;
      logic [3:0] p, q;
      logic c;
      {c, p, q} = 9'(i);
      apply(2'b00, p, q, {3'b000, c}, 1'b1);
      s = {1'b0, p} + {1'b0, q} + {4'b0, c};
      check("R2/R1 add", {3'b0, flag_out[0], result}, {3'b0, s});
      check("R5 borrow on add", {7'b0, flag_out[1]}, {7'b0, (p < q)});
      check("R6 spare", {6'b0, flag_out[3:2]}, 8'h00);
    end
  endtask

  task automatic t_sub_chain();
    for (int i = 0; i < 512; i++) begin
      logic [3:0] p, q;
      logic b;
      logic [4:0] qb;
      {b, p, q} = 9'(i);
      apply(2'b01, p, q, {2'b00, b, 1'b0}, 1'b1);
      qb = {1'b0, q} + {4'b0, b};
      check("R3/R1 sub diff", {4'b0, result}, {4'b0, 4'(p - q - {3'b0, b})});
      check("R3 borrow", {7'b0, flag_out[1]}, {7'b0, ({1'b0, p} < qb)});
      check("R5 carry on sub", {7'b0, flag_out[0]}, {7'b0, ((5'(p) + 5'(q)) > 5'd15)});
    end
  endtask

  task automatic t_chain_off();
    for (int i = 0; i < 256; i++) begin
      logic [3:0] p, q;
      logic [4:0] s;
      {p, q} = 8'(i);
      apply(2'b00, p, q, 4'hF, 1'b0);
      s = {1'b0, p} + {1'b0, q};
      check("R4 add ignores flags", {3'b0, flag_out[0], result}, {3'b0, s});
      check("R6 spare with flags high", {6'b0, flag_out[3:2]}, 8'h00);
      apply(2'b01, p, q, 4'hF, 1'b0);
      check("R4 sub ignores flags", {3'b0, flag_out[1], result}, {3'b0, (p < q), 4'(p - q)});
    end
  endtask

  task automatic t_logic();
    for (int i = 0; i < 256; i++) begin
      logic [3:0] p, q;
      {p, q} = 8'(i);
      apply(2'b10, p, q, 4'h3, 1'b1);
      check("R7/R1 and", {4'b0, result}, {4'b0, p & q});
      check("R5 flags on and", {4'b0, flag_out},
            {6'b0, ({1'b0, p} < ({1'b0, q} + 5'd1)), ((5'(p) + 5'(q) + 5'd1) > 5'd15)});
      apply(2'b11, p, q, 4'h0, 1'b0);
      check("R8/R1 or", {4'b0, result}, {4'b0, p | q});
      check("R5 flags on or", {4'b0, flag_out},
            {6'b0, (p < q), ((5'(p) + 5'(q)) > 5'd15)});
    end
  endtask

  task automatic t_no_clock();
    // R9: an input change shows at the output between clock edges
    @(posedge clk);
    #2;
    apply(2'b00, 4'h9, 4'h8, 4'h0, 1'b0);
    check("R9 settle 1", {3'b0, flag_out[0], result}, 8'h11);
    apply(2'b00, 4'h9, 4'h8, 4'h1, 1'b1);
    check("R9 settle 2", {3'b0, flag_out[0], result}, 8'h12);
    apply(2'b01, 4'h0, 4'h0, 4'h2, 1'b1);
    check("R9 settle 3", {3'b0, flag_out[1], result}, 8'h1F);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    apply(2'b00, 4'h0, 4'h0, 4'h0, 1'b0);
    check("R2 initial state", {flag_out, result}, 8'h00);
    t_add_chain();
    t_sub_chain();
    t_chain_off();
    t_logic();
    t_no_clock();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule